// File: doc/BRIEF.md
# Modem Control and Sync Pin Unit

This block runs the three modem-control pins of one serial channel. The clear-to-send pin, which is active low, can gate the transmitter. In loop mode the same pin turns around and becomes a loop-control output, which only explicit commands move. The carrier-detect pin, also active low, can gate the receiver, can be read as a plain level, or can act as an external character-sync input. The request-to-send pin is either a program-controlled output or a sync-detect indicator. As an indicator it follows the receiver's sync detection, one bit time late.

Both input pins pass through a synchronizer. Their level changes set sticky change flags, and each flag has its own interrupt mask. The framing logic of the channel supplies the configuration bits, the command strobes, the receiver's sync-detect level and a bit-time strobe. It takes back the enables, the pin drive and output-enable values, and the interrupt lines.

Top module: `mdm_pin_unit`

## Requirements
- R1: `tx_enable_o` is 1 when transmit gating is off or loop mode is on. Otherwise it is 1 exactly when the synchronized clear-to-send pin is low. A pin change reaches the synchronized level after SYNC_STAGES clock edges.
- R2: `cts_level_o` and `dcd_level_o` are 1 when their synchronized pins are low. `rx_enable_o` is 1 unless receive gating is on with external sync off, and in that case it equals `dcd_level_o`. `rx_ext_sync_o` equals `dcd_level_o` while external sync is selected and is 0 otherwise.
- R3: A level change of a synchronized input sets its change flag one edge after the new level appears. The flag stays set until a one is written to its clear strobe. If a change and a clear come in the same cycle, the set wins.
- R4: While loop mode is on, clear-to-send pin changes set no flag.
- R5: `irq_cts_o` and `irq_dcd_o` are 1 exactly when the matching flag and the matching interrupt enable are both 1.
- R6: `cts_oe_o` follows `cfg_loop_i` one clock later. One clock after loop mode is left, `cts_drive_n_o` is 1.
- R7: In loop mode, `cmd_loop_on_i` drives `cts_drive_n_o` low and `cmd_loop_off_i` drives it high. Outside loop mode both commands are ignored.
- R8: In sync-indicator mode (`cfg_rts_sync_i`=1), `rts_drive_n_o` goes low at the first `bit_tick_i` after the cycle in which `rx_sync_det_i` rises. A tick in the same cycle as the rise does not count.
- R9: The sync indicator returns high at the first tick on which detection is low and no restarted delay is pending. A new detection while the indicator is held restarts the one-tick delay, so release comes one tick later.
- R10: In program mode (`cfg_rts_sync_i`=0), `cmd_rts_set_i` drives `rts_drive_n_o` low and `cmd_rts_clr_i` drives it high. If both come in the same cycle, clear wins.
- R11: After reset both drive outputs are 1, `cts_oe_o` is 0, and both flags and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_pin_n_i | input | 1 | Clear-to-send pin level, active low |
| dcd_pin_n_i | input | 1 | Carrier-detect pin level, active low |
| cfg_cts_txen_i | input | 1 | Clear-to-send gates the transmitter |
| cfg_loop_i | input | 1 | Loop mode: clear-to-send pin becomes an output |
| cfg_dcd_rxen_i | input | 1 | Carrier-detect gates the receiver |
| cfg_dcd_extsync_i | input | 1 | Carrier-detect is the external sync input |
| cfg_rts_sync_i | input | 1 | Request-to-send pin shows sync detect (1) or the program bit (0) |
| cfg_ie_cts_i | input | 1 | Clear-to-send change interrupt enable |
| cfg_ie_dcd_i | input | 1 | Carrier-detect change interrupt enable |
| cmd_loop_on_i | input | 1 | Strobe: assert the loop-control output |
| cmd_loop_off_i | input | 1 | Strobe: negate the loop-control output |
| cmd_rts_set_i | input | 1 | Strobe: assert the program request-to-send |
| cmd_rts_clr_i | input | 1 | Strobe: negate the program request-to-send |
| clr_cts_chg_i | input | 1 | Write-one clear of the clear-to-send change flag |
| clr_dcd_chg_i | input | 1 | Write-one clear of the carrier-detect change flag |
| rx_sync_det_i | input | 1 | Receiver sync or flag detection level |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| tx_enable_o | output | 1 | Transmitter enable |
| rx_enable_o | output | 1 | Receiver enable |
| rx_ext_sync_o | output | 1 | External character-sync request to the receiver |
| cts_level_o | output | 1 | Synchronized clear-to-send, 1 = asserted |
| dcd_level_o | output | 1 | Synchronized carrier-detect, 1 = asserted |
| cts_drive_n_o | output | 1 | Value driven on the clear-to-send pin, active low |
| cts_oe_o | output | 1 | Output enable of the clear-to-send pin |
| rts_drive_n_o | output | 1 | Value driven on the request-to-send pin, active low |
| cts_chg_o | output | 1 | Sticky clear-to-send change flag |
| dcd_chg_o | output | 1 | Sticky carrier-detect change flag |
| irq_cts_o | output | 1 | Clear-to-send change interrupt |
| irq_dcd_o | output | 1 | Carrier-detect change interrupt |

## Verification
The bench builds the block with its default two-stage synchronizer. With two stages, the cycle in which a pin change shows up as a level and the cycle in which it shows up as a flag are both fixed, so they can be checked exactly. Every combination of gating bit, mode bit and pin level is swept for both enables and the external sync output. The sync indicator is driven through the corner cases by hand: a rise on the same cycle as a tick, a release held while detection stays high, and a restart during the hold.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic {
    RTS_PROGRAM  = 1'b0,
    RTS_SYNC_OUT = 1'b1
  } rts_role_e;

  localparam int MDM_NPINS = 2;
  localparam int MDM_CTS   = 0;
  localparam int MDM_DCD   = 1;
endpackage

// File: rtl/mdm_pin_watch.sv
module mdm_pin_watch #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  input  logic det_en_i,
  input  logic clr_i,
  output logic level_o,
  output logic chg_o
);
  logic [STAGES-1:0] sr_q, sr_d;
  logic              prev_q, prev_d;
  logic              chg_q, chg_d;
  logic              edge_seen;

  assign edge_seen = sr_q[STAGES-1] ^ prev_q;

  always_comb begin
    sr_d   = {sr_q[STAGES-2:0], pin_n_i};
    prev_d = sr_q[STAGES-1];
    chg_d  = chg_q;
    if (clr_i)                chg_d = 1'b0;
    if (det_en_i && edge_seen) chg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      prev_q <= 1'b1;
      chg_q  <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      prev_q <= prev_d;
      chg_q  <= chg_d;
    end
  end

  assign level_o = ~sr_q[STAGES-1];
  assign chg_o   = chg_q;
endmodule

// File: rtl/mdm_loop_ctl.sv
module mdm_loop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_i,
  input  logic on_i,
  input  logic off_i,
  output logic drive_n_o,
  output logic oe_o
);
  logic ctl_q, ctl_d;
  logic oe_q, oe_d;

  always_comb begin
    oe_d  = loop_i;
    ctl_d = ctl_q;
    if (!loop_i)    ctl_d = 1'b0;
    else if (off_i) ctl_d = 1'b0;
    else if (on_i)  ctl_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      oe_q  <= oe_d;
    end
  end

  assign drive_n_o = ~ctl_q;
  assign oe_o      = oe_q;
endmodule

// File: rtl/mdm_sync_delay.sv
module mdm_sync_delay (
  input  logic clk,
  input  logic rst_n,
  input  logic det_i,
  input  logic tick_i,
  output logic out_o
);
  logic det_q, pend_q, pend_d, out_q, out_d;
  logic rise;

  assign rise = det_i & ~det_q;

  always_comb begin
    pend_d = pend_q;
    out_d  = out_q;
    if (rise)        pend_d = 1'b1;
    else if (tick_i) pend_d = 1'b0;
    if (tick_i && !rise) begin
      if (pend_q)      out_d = 1'b1;
      else if (!det_i) out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q  <= 1'b0;
      pend_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      det_q  <= det_i;
      pend_q <= pend_d;
      out_q  <= out_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/mdm_pin_unit.sv
module mdm_pin_unit
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_pin_n_i,
  input  logic dcd_pin_n_i,
  input  logic cfg_cts_txen_i,
  input  logic cfg_loop_i,
  input  logic cfg_dcd_rxen_i,
  input  logic cfg_dcd_extsync_i,
  input  logic cfg_rts_sync_i,
  input  logic cfg_ie_cts_i,
  input  logic cfg_ie_dcd_i,
  input  logic cmd_loop_on_i,
  input  logic cmd_loop_off_i,
  input  logic cmd_rts_set_i,
  input  logic cmd_rts_clr_i,
  input  logic clr_cts_chg_i,
  input  logic clr_dcd_chg_i,
  input  logic rx_sync_det_i,
  input  logic bit_tick_i,
  output logic tx_enable_o,
  output logic rx_enable_o,
  output logic rx_ext_sync_o,
  output logic cts_level_o,
  output logic dcd_level_o,
  output logic cts_drive_n_o,
  output logic cts_oe_o,
  output logic rts_drive_n_o,
  output logic cts_chg_o,
  output logic dcd_chg_o,
  output logic irq_cts_o,
  output logic irq_dcd_o
);
  logic [MDM_NPINS-1:0] pin_n, det_en, clr, lvl, chg;
  logic                 sync_out;
  logic                 rts_q, rts_d;
  rts_role_e            rts_role;

  assign pin_n[MDM_CTS]  = cts_pin_n_i;
  assign pin_n[MDM_DCD]  = dcd_pin_n_i;
  assign det_en[MDM_CTS] = ~cfg_loop_i;
  assign det_en[MDM_DCD] = 1'b1;
  assign clr[MDM_CTS]    = clr_cts_chg_i;
  assign clr[MDM_DCD]    = clr_dcd_chg_i;

  for (genvar g = 0; g < MDM_NPINS; g++) begin : g_watch
    mdm_pin_watch #(.STAGES(SYNC_STAGES)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n_i  (pin_n[g]),
      .det_en_i (det_en[g]),
      .clr_i    (clr[g]),
      .level_o  (lvl[g]),
      .chg_o    (chg[g])
    );
  end

  mdm_loop_ctl u_loop (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_i    (cfg_loop_i),
    .on_i      (cmd_loop_on_i),
    .off_i     (cmd_loop_off_i),
    .drive_n_o (cts_drive_n_o),
    .oe_o      (cts_oe_o)
  );

  mdm_sync_delay u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .det_i  (rx_sync_det_i),
    .tick_i (bit_tick_i),
    .out_o  (sync_out)
  );

  always_comb begin
    rts_d = rts_q;
    if (cmd_rts_clr_i)      rts_d = 1'b0;
    else if (cmd_rts_set_i) rts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b0;
    else        rts_q <= rts_d;
  end

  assign rts_role      = rts_role_e'(cfg_rts_sync_i);
  assign rts_drive_n_o = (rts_role == RTS_SYNC_OUT) ? ~sync_out : ~rts_q;

  assign cts_level_o   = lvl[MDM_CTS];
  assign dcd_level_o   = lvl[MDM_DCD];
  assign tx_enable_o   = (cfg_cts_txen_i && !cfg_loop_i) ? lvl[MDM_CTS] : 1'b1;
  assign rx_enable_o   = (cfg_dcd_rxen_i && !cfg_dcd_extsync_i) ? lvl[MDM_DCD] : 1'b1;
  assign rx_ext_sync_o = cfg_dcd_extsync_i & lvl[MDM_DCD];
  assign cts_chg_o     = chg[MDM_CTS];
  assign dcd_chg_o     = chg[MDM_DCD];
  assign irq_cts_o     = chg[MDM_CTS] & cfg_ie_cts_i;
  assign irq_dcd_o     = chg[MDM_DCD] & cfg_ie_dcd_i;
endmodule

// File: rtl/mdm_pin_unit_chk.sv
module mdm_pin_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_loop_i,
  input logic cfg_rts_sync_i,
  input logic cmd_loop_on_i,
  input logic cmd_loop_off_i,
  input logic cmd_rts_set_i,
  input logic cmd_rts_clr_i,
  input logic clr_cts_chg_i,
  input logic bit_tick_i,
  input logic cts_drive_n_o,
  input logic cts_oe_o,
  input logic rts_drive_n_o,
  input logic cts_chg_o
);
  assert_chg_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cts_chg_o && !clr_cts_chg_i |=> cts_chg_o);

  assert_oe_follows_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loop_i |=> cts_oe_o);

  assert_loop_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_loop_i |=> (!cts_oe_o && cts_drive_n_o));

  assert_loop_cmd_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loop_i && $past(cfg_loop_i) && !$stable(cts_drive_n_o)
    |-> $past(cmd_loop_on_i || cmd_loop_off_i));

  assert_sync_set_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rts_sync_i && $past(cfg_rts_sync_i) && $fell(rts_drive_n_o) |-> $past(bit_tick_i));

  assert_sync_release_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rts_sync_i && $past(cfg_rts_sync_i) && $rose(rts_drive_n_o) |-> $past(bit_tick_i));

  assert_prog_rts_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rts_sync_i && $past(!cfg_rts_sync_i) && !$stable(rts_drive_n_o)
    |-> $past(cmd_rts_set_i || cmd_rts_clr_i));
endmodule

bind mdm_pin_unit mdm_pin_unit_chk chk_i (.*);

// File: tb/mdm_pin_unit_tb_top.sv
module mdm_pin_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic cts_pin_n, dcd_pin_n, cts_txen, loop_m, dcd_rxen, dcd_ext, rts_sync;
  logic ie_cts, ie_dcd, loop_on, loop_off, rts_set, rts_clr, clr_cts, clr_dcd;
  logic sync_det, tick;
  logic tx_en, rx_en, ext_sync, cts_lvl, dcd_lvl, cts_drv_n, cts_oe, rts_drv_n;
  logic cts_chg, dcd_chg, irq_cts, irq_dcd;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mdm_pin_unit #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cts_pin_n_i(cts_pin_n), .dcd_pin_n_i(dcd_pin_n),
    .cfg_cts_txen_i(cts_txen), .cfg_loop_i(loop_m), .cfg_dcd_rxen_i(dcd_rxen),
    .cfg_dcd_extsync_i(dcd_ext), .cfg_rts_sync_i(rts_sync), .cfg_ie_cts_i(ie_cts),
    .cfg_ie_dcd_i(ie_dcd), .cmd_loop_on_i(loop_on), .cmd_loop_off_i(loop_off),
    .cmd_rts_set_i(rts_set), .cmd_rts_clr_i(rts_clr), .clr_cts_chg_i(clr_cts),
    .clr_dcd_chg_i(clr_dcd), .rx_sync_det_i(sync_det), .bit_tick_i(tick),
    .tx_enable_o(tx_en), .rx_enable_o(rx_en), .rx_ext_sync_o(ext_sync),
    .cts_level_o(cts_lvl), .dcd_level_o(dcd_lvl), .cts_drive_n_o(cts_drv_n),
    .cts_oe_o(cts_oe), .rts_drive_n_o(rts_drv_n), .cts_chg_o(cts_chg),
    .dcd_chg_o(dcd_chg), .irq_cts_o(irq_cts), .irq_dcd_o(irq_dcd)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1; step(1); tick = 1'b0;
  endtask

  task automatic clear_flags();
    clr_cts = 1'b1; clr_dcd = 1'b1; step(1); clr_cts = 1'b0; clr_dcd = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cts_pin_n = 1; dcd_pin_n = 1; cts_txen = 0; loop_m = 0; dcd_rxen = 0; dcd_ext = 0;
    rts_sync = 0; ie_cts = 0; ie_dcd = 0; loop_on = 0; loop_off = 0; rts_set = 0;
    rts_clr = 0; clr_cts = 0; clr_dcd = 0; sync_det = 0; tick = 0;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R11 reset state
    chk("R11 cts_drive", cts_drv_n, 1'b1);
    chk("R11 rts_drive", rts_drv_n, 1'b1);
    chk("R11 cts_oe", cts_oe, 1'b0);
    chk("R11 cts_chg", cts_chg, 1'b0);
    chk("R11 dcd_chg", dcd_chg, 1'b0);
    chk("R11 irq_cts", irq_cts, 1'b0);

    // R1 sweep of transmit gating, loop mode and pin level
    for (int v = 0; v < 8; v++) begin
      cts_txen = v[0]; loop_m = v[1]; cts_pin_n = v[2];
      step(4);
      chk("R1 tx_enable", tx_en, (v[0] && !v[1]) ? !v[2] : 1'b1);
      chk("R2 cts_level", cts_lvl, !v[2]);
    end
    loop_m = 0; cts_pin_n = 1; cts_txen = 0;
    step(4);

    // R2 sweep of receive gating, external sync and pin level
    for (int v = 0; v < 8; v++) begin
      dcd_rxen = v[0]; dcd_ext = v[1]; dcd_pin_n = v[2];
      step(4);
      chk("R2 rx_enable", rx_en, (v[0] && !v[1]) ? !v[2] : 1'b1);
      chk("R2 rx_ext_sync", ext_sync, v[1] && !v[2]);
      chk("R2 dcd_level", dcd_lvl, !v[2]);
    end
    dcd_rxen = 0; dcd_ext = 0; dcd_pin_n = 1;
    step(4);
    clear_flags();
    step(1);

    // R3 flag timing and stickiness
    chk("R3 cts_chg cleared", cts_chg, 1'b0);
    cts_pin_n = 0;
    step(2);
    chk("R3 level after sync", cts_lvl, 1'b1);
    chk("R3 flag not yet", cts_chg, 1'b0);
    step(1);
    chk("R3 flag set", cts_chg, 1'b1);
    cts_pin_n = 1;
    step(4);
    chk("R3 flag sticky", cts_chg, 1'b1);
    // R5 masking
    chk("R5 irq masked", irq_cts, 1'b0);
    ie_cts = 1; step(1);
    chk("R5 irq enabled", irq_cts, 1'b1);
    clr_cts = 1; step(1); clr_cts = 0;
    chk("R3 flag cleared by write", cts_chg, 1'b0);
    chk("R5 irq drops", irq_cts, 1'b0);
    // R3 set wins over clear in the same cycle
    cts_pin_n = 0;
    step(2);
    clr_cts = 1; step(1); clr_cts = 0;
    chk("R3 set wins", cts_chg, 1'b1);
    cts_pin_n = 1; step(4); clear_flags(); step(1);
    // dcd flag and its interrupt
    dcd_pin_n = 0; step(3);
    chk("R3 dcd flag", dcd_chg, 1'b1);
    chk("R5 irq_dcd masked", irq_dcd, 1'b0);
    ie_dcd = 1; step(1);
    chk("R5 irq_dcd", irq_dcd, 1'b1);
    dcd_pin_n = 1; step(4); clear_flags(); step(1);

    // R4 and R6: loop mode
    loop_m = 1; step(1);
    chk("R6 oe on", cts_oe, 1'b1);
    chk("R6 drive negated on entry", cts_drv_n, 1'b1);
    cts_pin_n = 0; step(4);
    cts_pin_n = 1; step(4);
    chk("R4 no flag in loop", cts_chg, 1'b0);
    chk("R4 no irq in loop", irq_cts, 1'b0);
    // R7 commands in loop mode
    loop_on = 1; step(1); loop_on = 0;
    chk("R7 loop on", cts_drv_n, 1'b0);
    loop_off = 1; step(1); loop_off = 0;
    chk("R7 loop off", cts_drv_n, 1'b1);
    loop_on = 1; step(1); loop_on = 0;
    loop_m = 0; step(1);
    chk("R6 oe off on exit", cts_oe, 1'b0);
    chk("R6 drive negated on exit", cts_drv_n, 1'b1);
    step(3);
    chk("R4 no flag after exit", cts_chg, 1'b0);
    // R7 commands ignored outside loop mode
    loop_on = 1; step(1); loop_on = 0;
    loop_m = 1; step(2);
    chk("R7 ignored outside loop", cts_drv_n, 1'b1);
    loop_m = 0; step(2);

    // R10 program mode
    rts_set = 1; step(1); rts_set = 0;
    chk("R10 set", rts_drv_n, 1'b0);
    rts_clr = 1; step(1); rts_clr = 0;
    chk("R10 clear", rts_drv_n, 1'b1);
    rts_set = 1; rts_clr = 1; step(1); rts_set = 0; rts_clr = 0;
    chk("R10 clear wins", rts_drv_n, 1'b1);
    rts_set = 1; step(1); rts_set = 0;

    // R8/R9 sync indicator mode
    rts_sync = 1; step(1);
    chk("R8 idle", rts_drv_n, 1'b1);
    sync_det = 1; step(1);
    chk("R8 not before tick", rts_drv_n, 1'b1);
    pulse_tick();
    chk("R8 asserted after tick", rts_drv_n, 1'b0);
    pulse_tick();
    chk("R9 held while detect", rts_drv_n, 1'b0);
    sync_det = 0; step(2);
    chk("R9 held until tick", rts_drv_n, 1'b0);
    pulse_tick();
    chk("R9 released", rts_drv_n, 1'b1);
    // restart during hold
    sync_det = 1; step(1); pulse_tick();
    chk("R8 second assert", rts_drv_n, 1'b0);
    sync_det = 0; step(1);
    sync_det = 1; step(1);
    sync_det = 0; step(1);
    pulse_tick();
    chk("R9 restart holds", rts_drv_n, 1'b0);
    pulse_tick();
    chk("R9 release after restart", rts_drv_n, 1'b1);
    // rise on the same cycle as a tick
    sync_det = 1; tick = 1; step(1); tick = 0;
    chk("R8 same-cycle tick ignored", rts_drv_n, 1'b1);
    pulse_tick();
    chk("R8 next tick asserts", rts_drv_n, 1'b0);
    sync_det = 0; pulse_tick();
    chk("R9 final release", rts_drv_n, 1'b1);
    // R10 program state kept across the mode switch
    rts_sync = 0; step(1);
    chk("R10 program state kept", rts_drv_n, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule